// File: doc/BRIEF.md
# Expansion ROM Base Register and Window Decoder

This block holds the configuration-space base register that places an option ROM in memory space, and decodes memory addresses against the window that register opens. The window size is fixed when the block is built. It is the smallest power of two that is at least 2 KB and at least the image size given as a parameter, and it may not exceed 4 MB. From that size the block derives an address mask that is the bitwise inverse of (size − 1). An image size of zero means no ROM is fitted. In that case the mask is zero and the register is inert.

Software writes the register to size and place the window. The block treats a write as a sizing probe when the written data has a one in every bit position the mask covers. It does not compare the data with all ones. A sizing probe is stored but does not move the window. Any other write stores its data and then opens the window or closes it. The window opens only when the enable bit (bit 0) is set and the masked base is nonzero. When a mapped window is moved to a new base, it first closes for one cycle and then opens at the new base. Incoming memory addresses produce a hit flag and an offset into the ROM, which an external ROM array uses.

Top module: `erom_bar_decoder`

## Requirements
- R1: The window size is the smallest power of two that is at least 2048 and at least IMAGE_BYTES, capped at 4 MB, which is checked at elaboration. The mask is ~(size − 1). With the default IMAGE_BYTES of 0x1234, the size is 0x2000 and the mask is 0xFFFFE000.
- R2: With IMAGE_BYTES = 0, writes are ignored, `bar_rdata` reads zero, and `win_mapped` and `rom_hit` stay low.
- R3: Every accepted write stores data AND (mask OR 1), and the result is visible on `bar_rdata` in the cycle after the write.
- R4: A sizing write, meaning (data AND mask) == mask, leaves `win_mapped` and `win_base` unchanged.
- R5: A non-sizing write with bit 0 set and a nonzero (data AND mask) raises `win_mapped` in the next cycle, with `win_base` = data AND mask.
- R6: A non-sizing write with bit 0 clear lowers `win_mapped` in the next cycle, and `win_base` then reads zero.
- R7: A non-sizing write whose masked base is zero leaves the window unmapped, even with bit 0 set.
- R8: If an enabling write gives a mapped window a different base, `win_mapped` is low for exactly one cycle and then high with the new base. The same base keeps the window mapped with no gap.
- R9: `rom_hit` = `mem_valid` AND `win_mapped` AND ((`mem_addr` AND mask) == `win_base`), combinational in the same cycle.
- R10: `rom_offset` = `mem_addr` AND NOT mask, combinational.
- R11: While `rst_n` is low at a clock edge, `bar_rdata`, `win_mapped` and `win_base` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe for the ROM base register |
| cfg_wr_data | input | ADDR_W | Configuration write data |
| bar_rdata | output | ADDR_W | Stored register value for configuration reads |
| win_mapped | output | 1 | Decode window is active |
| win_base | output | ADDR_W | Base of the active window, zero when unmapped |
| mem_valid | input | 1 | Memory address qualifier |
| mem_addr | input | ADDR_W | Memory address to decode |
| rom_hit | output | 1 | Address falls in the active window |
| rom_offset | output | ADDR_W | Byte offset into the ROM |

## Verification
Register contents and the mapping state are due one clock edge after the write strobe is sampled. When a mapped window moves to a new base, the mapping state settles after a second edge. Hit and offset are combinational and are due in the same cycle that the address is applied. The bench drives writes on falling edges and reads the register and the first mapping state at the next falling edge. It reads the settled mapping one falling edge later, and it samples the decode result a short delay after the address changes, well clear of any rising edge.

// File: rtl/erom_pkg.sv
// Shared constants and build-time helpers for the expansion ROM window.
// Assumes image sizes are given in bytes and fit in 32 bits.
package erom_pkg;

    localparam int unsigned MIN_ROM_BYTES = 32'd2048;
    localparam int unsigned MAX_ROM_BYTES = 32'd4194304;

    // Smallest power of two >= MIN_ROM_BYTES and >= image (0 -> MIN).
    function automatic int unsigned rom_bytes_f(input int unsigned image);
        int unsigned s;
        s = MIN_ROM_BYTES;
        for (int i = 0; i < 13; i++) begin
            if (s < image) s = s << 1;
        end
        return s;
    endfunction

endpackage

// File: rtl/erom_size_cfg.sv
// Derives the window mask from the image size at elaboration.
// Assumes IMAGE_BYTES == 0 means no ROM fitted; mask is then all zeros.
module erom_size_cfg #(
    parameter int unsigned IMAGE_BYTES = 32'h1234,
    parameter int unsigned ADDR_W      = 32
) (
    output logic [ADDR_W-1:0] size_mask
);
    import erom_pkg::*;

    localparam bit          PRESENT   = (IMAGE_BYTES != 0);
    localparam int unsigned ROM_BYTES = rom_bytes_f(IMAGE_BYTES);
    localparam logic [ADDR_W-1:0] MASK_V =
        PRESENT ? ~ADDR_W'(ROM_BYTES - 1) : '0;

    // Build-time limits on the image size and address width.
    generate
        if (IMAGE_BYTES > MAX_ROM_BYTES) begin : g_too_big
            $error("erom_size_cfg: image exceeds 4 MB window limit");
        end
        if (ADDR_W < 23) begin : g_narrow
            $error("erom_size_cfg: ADDR_W too small for a 4 MB window");
        end
    endgenerate

    // Constant mask output.
    assign size_mask = MASK_V;

endmodule

// File: rtl/erom_bar_reg.sv
// Base register and mapping state machine for the ROM window.
// Assumes size_mask is constant; a zero mask means no ROM, writes ignored.
// A base move while mapped drops the window for one cycle before reopening.
module erom_bar_reg #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] size_mask,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    output logic [ADDR_W-1:0] bar_q,
    output logic              mapped_q,
    output logic [ADDR_W-1:0] base_q
);
    logic              present;
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] new_base;
    logic              is_sizing;
    logic              want_map;
    logic              pend_q;
    logic [ADDR_W-1:0] pend_base_q;

    // Classify the incoming write.
    always_comb begin
        present   = |size_mask;
        keep_mask = size_mask | ADDR_W'(1);
        new_base  = cfg_wr_data & size_mask;
        is_sizing = (new_base == size_mask);
        want_map  = cfg_wr_data[0] && (|new_base);
    end

    // Register storage, mapping and the deferred reopen after a base move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q       <= '0;
            mapped_q    <= 1'b0;
            base_q      <= '0;
            pend_q      <= 1'b0;
            pend_base_q <= '0;
        end else begin
            if (pend_q) begin
                mapped_q <= 1'b1;
                base_q   <= pend_base_q;
                pend_q   <= 1'b0;
            end
            if (cfg_wr_en && present) begin
                bar_q <= cfg_wr_data & keep_mask;
                if (!is_sizing) begin
                    if (want_map && mapped_q && (base_q != new_base)) begin
                        mapped_q    <= 1'b0;
                        base_q      <= '0;
                        pend_q      <= 1'b1;
                        pend_base_q <= new_base;
                    end else if (want_map) begin
                        mapped_q <= 1'b1;
                        base_q   <= new_base;
                        pend_q   <= 1'b0;
                    end else begin
                        mapped_q <= 1'b0;
                        base_q   <= '0;
                        pend_q   <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/erom_window_dec.sv
// Combinational address decoder for the mapped ROM window.
// Assumes base is already aligned to the mask when mapped is high.
module erom_window_dec #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] size_mask,
    input  logic              mapped,
    input  logic [ADDR_W-1:0] base,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    // Compare the masked address and split off the in-window offset.
    always_comb begin
        hit    = mem_valid && mapped && ((mem_addr & size_mask) == base);
        offset = mem_addr & ~size_mask;
    end

endmodule

// File: rtl/erom_bar_decoder.sv
// Top: expansion ROM base register plus memory window decoder.
// Assumes one configuration write per strobe cycle; decode is same-cycle.
module erom_bar_decoder #(
    parameter int unsigned IMAGE_BYTES = 32'h1234,
    parameter int unsigned ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    output logic [ADDR_W-1:0] bar_rdata,
    output logic              win_mapped,
    output logic [ADDR_W-1:0] win_base,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              rom_hit,
    output logic [ADDR_W-1:0] rom_offset
);
    logic [ADDR_W-1:0] size_mask;

    // Size and mask derivation.
    erom_size_cfg #(.IMAGE_BYTES(IMAGE_BYTES), .ADDR_W(ADDR_W)) u_size (
        .size_mask(size_mask)
    );

    // Register and mapping state.
    erom_bar_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_mask  (size_mask),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_data(cfg_wr_data),
        .bar_q      (bar_rdata),
        .mapped_q   (win_mapped),
        .base_q     (win_base)
    );

    // Address decode.
    erom_window_dec #(.ADDR_W(ADDR_W)) u_dec (
        .size_mask(size_mask),
        .mapped   (win_mapped),
        .base     (win_base),
        .mem_valid(mem_valid),
        .mem_addr (mem_addr),
        .hit      (rom_hit),
        .offset   (rom_offset)
    );

endmodule

// File: rtl/erom_bar_chk.sv
// Checker for erom_bar_decoder, bound to every instance below.
// Recomputes the mask from the package helper and watches the ports only.
module erom_bar_chk #(
    parameter int unsigned IMAGE_BYTES = 32'h1234,
    parameter int unsigned ADDR_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_wr_data,
    input logic [ADDR_W-1:0] bar_rdata,
    input logic              win_mapped,
    input logic [ADDR_W-1:0] win_base,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rom_hit,
    input logic [ADDR_W-1:0] rom_offset
);
    import erom_pkg::*;

    localparam bit PRESENT = (IMAGE_BYTES != 0);
    localparam logic [ADDR_W-1:0] MASK =
        PRESENT ? ~ADDR_W'(rom_bytes_f(IMAGE_BYTES) - 1) : '0;

    logic [ADDR_W-1:0] wr_base;
    logic              wr_sizing;
    assign wr_base   = cfg_wr_data & MASK;
    assign wr_sizing = (wr_base == MASK);

    // R2
    no_rom_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !PRESENT |-> (bar_rdata == '0) && !win_mapped && !rom_hit);

    // R3
    rdata_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_rdata & ~(MASK | ADDR_W'(1))) == '0);

    // R4
    sizing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && cfg_wr_en && wr_sizing && !$past(cfg_wr_en))
        |=> $stable(win_mapped) && $stable(win_base));

    // R6
    disable_unmap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && cfg_wr_en && !wr_sizing && !cfg_wr_data[0]) |=> !win_mapped);

    // R7
    zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && cfg_wr_en && (wr_base == '0)) |=> !win_mapped);

    // R8
    move_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && cfg_wr_en && !wr_sizing && cfg_wr_data[0] && (wr_base != '0)
         && win_mapped && (wr_base != win_base)) |=> !win_mapped);

    // R9
    hit_needs_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_hit |-> (win_mapped && mem_valid));

    // R10
    offset_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_offset & MASK) == '0);

endmodule

bind erom_bar_decoder erom_bar_chk #(.IMAGE_BYTES(IMAGE_BYTES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_data(cfg_wr_data),
    .bar_rdata  (bar_rdata),
    .win_mapped (win_mapped),
    .win_base   (win_base),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .rom_hit    (rom_hit),
    .rom_offset (rom_offset)
);

// File: tb/erom_bar_decoder_tb.sv
`timescale 1ns/1ps
module erom_bar_decoder_tb;

    localparam logic [31:0] WIN_SIZE = 32'h2000;           // R1: image 0x1234 -> 8 KB
    localparam logic [31:0] MASK     = ~(WIN_SIZE - 32'd1); // 0xFFFFE000

    typedef struct packed {
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        map1;
        logic        map2;
        logic [31:0] exp_base;
        logic [31:0] probe;
        logic        exp_hit;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{32'hFFFF_FFFF, 32'hFFFF_E001, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0010, 1'b0},
        '{32'h8000_0001, 32'h8000_0001, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_1234, 1'b1},
        '{32'h8000_4001, 32'h8000_4001, 1'b0, 1'b1, 32'h8000_4000, 32'h8000_5FFC, 1'b1},
        '{32'hFFFF_E000, 32'hFFFF_E000, 1'b1, 1'b1, 32'h8000_4000, 32'h8000_4010, 1'b1},
        '{32'h8000_4000, 32'h8000_4000, 1'b0, 1'b0, 32'h0000_0000, 32'h8000_4010, 1'b0},
        '{32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0004, 1'b0},
        '{32'h4000_0FFF, 32'h4000_0001, 1'b1, 1'b1, 32'h4000_0000, 32'h4000_1FFF, 1'b1},
        '{32'h4000_0001, 32'h4000_0001, 1'b1, 1'b1, 32'h4000_0000, 32'h4000_0800, 1'b1},
        '{32'hC000_0001, 32'hC000_0001, 1'b0, 1'b1, 32'hC000_0000, 32'h4000_0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [31:0] cfg_wr_data;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] bar_rdata, win_base, rom_offset;
    logic        win_mapped, rom_hit;
    logic [31:0] e_rdata, e_base, e_offset;
    logic        e_mapped, e_hit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    erom_bar_decoder #(.IMAGE_BYTES(32'h1234), .ADDR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .bar_rdata(bar_rdata), .win_mapped(win_mapped), .win_base(win_base),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .rom_hit(rom_hit),
        .rom_offset(rom_offset)
    );

    erom_bar_decoder #(.IMAGE_BYTES(32'd0), .ADDR_W(32)) u_empty (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .bar_rdata(e_rdata), .win_mapped(e_mapped), .win_base(e_base),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .rom_hit(e_hit),
        .rom_offset(e_offset)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
        mem_valid = 1'b0; mem_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 rdata", bar_rdata, 32'h0);
        chk("R11 mapped", {31'b0, win_mapped}, 32'h0);
        chk("R11 base", win_base, 32'h0);
        rst_n = 1'b1;

        // Table walk: R1 R3 R4 R5 R6 R7 R8 R9 R10, empty instance R2
        for (int i = 0; i < 10; i++) begin
            write_cfg(VECS[i].wdata);
            @(negedge clk);
            cfg_wr_en = 1'b0;
            chk($sformatf("R3 rdata v%0d", i), bar_rdata, VECS[i].exp_rd);
            chk($sformatf("R8 first map v%0d", i), {31'b0, win_mapped}, {31'b0, VECS[i].map1});
            @(negedge clk);
            chk($sformatf("R5 settled map v%0d", i), {31'b0, win_mapped}, {31'b0, VECS[i].map2});
            chk($sformatf("R6 base v%0d", i), win_base, VECS[i].exp_base);
            mem_valid = 1'b1;
            mem_addr  = VECS[i].probe;
            #1;
            chk($sformatf("R9 hit v%0d", i), {31'b0, rom_hit}, {31'b0, VECS[i].exp_hit});
            chk($sformatf("R10 offset v%0d", i), rom_offset, VECS[i].probe & ~MASK);
            chk($sformatf("R2 empty v%0d", i), {e_rdata[31:1], e_rdata[0] | e_mapped | e_hit}, 32'h0);
            mem_valid = 1'b0;
        end

        // R9: no hit without mem_valid, window at C0000000
        mem_addr = 32'hC000_0010;
        #1;
        chk("R9 valid low", {31'b0, rom_hit}, 32'h0);
        chk("R10 offset valid low", rom_offset, 32'h0000_0010);

        // R11: reset while mapped
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 mapped after reset", {31'b0, win_mapped}, 32'h0);
        chk("R11 rdata after reset", bar_rdata, 32'h0);
        rst_n = 1'b1;

        // R8/R4: sizing write during the reopen gap does not cancel the move
        write_cfg(32'h8000_0001);
        write_cfg(32'hA000_0001);
        @(negedge clk);
        chk("R8 gap", {31'b0, win_mapped}, 32'h0);
        cfg_wr_en = 1'b1; cfg_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk("R8 reopen", {31'b0, win_mapped}, 32'h1);
        chk("R8 new base", win_base, 32'hA000_0000);
        chk("R4 sizing stored", bar_rdata, 32'hFFFF_E001);
        chk("R1 mask readback", bar_rdata & ~32'h1, MASK);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule